// File: doc/BRIEF.md
# Four-Waveform Lookup Function Generator

This block produces a stream of unsigned amplitude samples for a digital-to-analog converter. A phase index walks through a period of 256 steps. For each step the block works out the amplitude of one of four shapes: sine, square, triangle or sawtooth. A two-bit selector picks the shape.

The square, triangle and sawtooth shapes are computed directly from the index with a small amount of arithmetic. The sine shape is read from a 256-entry table that is filled with constants when the design is elaborated.

Samples leave through a valid/ready pair, and the DAC side may stall the stream. A sample is produced only on a cycle where `step_en` is high and the output slot is free, which is the case when it is empty or is being taken by the consumer. The phase index moves forward only on those cycles. Stalling therefore holds both the presented sample and the phase. Pacing `step_en` sets the output frequency.

Top module: `wg_funcgen`

## Requirements
- R1: A synchronous reset, `rst` high at a clock edge, sets the phase index to 0 and clears `amp_valid`.
- R2: A sample is produced in a cycle where `step_en` is high and either `amp_valid` is low or `amp_ready` is high. After that edge, `amp_data` holds the amplitude for the index value before the edge and `amp_valid` is high. The index then advances by one and wraps from 255 to 0. In no other cycle does the index change.
- R3: While `amp_valid` is high and `amp_ready` is low, `amp_valid` and `amp_data` hold their values from one cycle to the next.
- R4: When a valid sample is taken (`amp_ready` high) in a cycle with `step_en` low, `amp_valid` is low after that edge.
- R5: `wave_sel` encodes the shape as 0 = sine, 1 = square, 2 = triangle, 3 = sawtooth. The value sampled in a producing cycle decides that sample's shape. Changing it does not disturb the phase index.
- R6: Square amplitude is 255 when the index is below 128 and 0 when it is 128 or above.
- R7: Sawtooth amplitude equals the index.
- R8: Triangle amplitude is computed by index range:
  - below 64: 128 + 2·index;
  - 64 to 191: 256 − 2·(index − 63);
  - 192 and above: 2·(index − 191).
- R9: Sine amplitude is 128·sin(2π·index/256) + 128 in double precision, truncated toward zero and clamped to 0..255. For example, index 0 gives 0x80, index 64 gives 0xFF and index 192 gives 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| step_en | input | 1 | Request to produce a sample and advance the phase |
| wave_sel | input | 2 | Shape code: 0 sine, 1 square, 2 triangle, 3 sawtooth |
| amp_ready | input | 1 | Consumer accepts the presented sample |
| amp_valid | output | 1 | A sample is presented on `amp_data` |
| amp_data | output | 8 | Unsigned amplitude sample |

## Verification
The assertions assume that `rst` is a clean synchronous pulse. They also assume that `wave_sel` and `step_en` are sampled only at the clock edge, with no meaning attached to their values between edges. The bench drives every input one time unit after the rising edge and reads outputs in the same place. It steps a cycle-accurate model that is built from the handshake rules and the shape formulas. The stimulus sweeps each shape through a full period and beyond the wrap. It then toggles the selector mid-stream, holds `amp_ready` low under a steady request, and drains the output with `step_en` low. Each of these cases stays inside the handshake contract.

// File: rtl/wg_pkg.sv
`timescale 1ns/1ps
package wg_pkg;
  typedef enum logic [1:0] {
    SHAPE_SINE   = 2'd0,
    SHAPE_SQUARE = 2'd1,
    SHAPE_TRI    = 2'd2,
    SHAPE_SAW    = 2'd3
  } shape_e;
endpackage

// File: rtl/wg_phase.sv
`timescale 1ns/1ps
module wg_phase #(
  parameter int PHASE_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               adv,
  output logic [PHASE_W-1:0] idx
);
  localparam logic [PHASE_W-1:0] IDX_LAST = {PHASE_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst)      idx <= '0;
    else if (adv) idx <= idx + 1'b1;
  end

  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (rst)
    (adv && idx != IDX_LAST) |=> idx == $past(idx) + 1'b1); // R2
  AST_PHASE_WRAP: assert property (@(posedge clk) disable iff (rst)
    (adv && idx == IDX_LAST) |=> idx == '0); // R2
  AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(idx)); // R2
endmodule

// File: rtl/wg_sine_rom.sv
`timescale 1ns/1ps
module wg_sine_rom #(
  parameter int PHASE_W = 8
) (
  input  logic [PHASE_W-1:0] idx,
  output logic [PHASE_W-1:0] amp
);
  localparam int  PERIOD = 1 << PHASE_W;
  localparam int  AMP_MAX = PERIOD - 1;
  localparam real TWO_PI = 6.283185307179586;

  function automatic logic [PHASE_W-1:0] sine_at(input int i);
    real a;
    int  v;
    a = real'(PERIOD / 2) * $sin(TWO_PI * real'(i) / real'(PERIOD)) + real'(PERIOD / 2);
    v = $rtoi(a);
    if (v > AMP_MAX) v = AMP_MAX;
    if (v < 0)       v = 0;
    return PHASE_W'(v);
  endfunction

  logic [PHASE_W-1:0] table_q [PERIOD];

  for (genvar g = 0; g < PERIOD; g++) begin : g_entry
    assign table_q[g] = sine_at(g);
  end

  assign amp = table_q[idx];
endmodule

// File: rtl/wg_shapes.sv
`timescale 1ns/1ps
module wg_shapes #(
  parameter int PHASE_W = 8
) (
  input  logic [PHASE_W-1:0] idx,
  output logic [PHASE_W-1:0] square_amp,
  output logic [PHASE_W-1:0] tri_amp,
  output logic [PHASE_W-1:0] saw_amp
);
  localparam int PERIOD  = 1 << PHASE_W;
  localparam int HALF    = PERIOD / 2;
  localparam int QUARTER = PERIOD / 4;

  int i_v;
  int tri_v;

  always_comb begin
    i_v = int'(idx);
    if (i_v < QUARTER)          tri_v = HALF + 2 * i_v;
    else if (i_v < 3 * QUARTER) tri_v = PERIOD - 2 * (i_v - (QUARTER - 1));
    else                        tri_v = 2 * (i_v - (3 * QUARTER - 1));
    tri_amp    = PHASE_W'(tri_v);
    square_amp = (i_v < HALF) ? {PHASE_W{1'b1}} : '0;
    saw_amp    = idx;
  end
endmodule

// File: rtl/wg_funcgen.sv
`timescale 1ns/1ps
module wg_funcgen
  import wg_pkg::*;
#(
  parameter int PHASE_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               step_en,
  input  logic [1:0]         wave_sel,
  input  logic               amp_ready,
  output logic               amp_valid,
  output logic [PHASE_W-1:0] amp_data
);
  localparam logic [PHASE_W-1:0] AMP_TOP = {PHASE_W{1'b1}};

  logic               adv;
  logic [PHASE_W-1:0] idx;
  logic [PHASE_W-1:0] sine_amp, square_amp, tri_amp, saw_amp;
  logic [PHASE_W-1:0] amp_next;
  shape_e             shape;

  assign adv   = step_en && (!amp_valid || amp_ready);
  assign shape = shape_e'(wave_sel);

  wg_phase #(.PHASE_W(PHASE_W)) u_phase (
    .clk (clk), .rst (rst), .adv (adv), .idx (idx)
  );

  wg_sine_rom #(.PHASE_W(PHASE_W)) u_sine (
    .idx (idx), .amp (sine_amp)
  );

  wg_shapes #(.PHASE_W(PHASE_W)) u_shapes (
    .idx (idx), .square_amp (square_amp), .tri_amp (tri_amp), .saw_amp (saw_amp)
  );

  always_comb begin
    unique case (shape)
      SHAPE_SINE:   amp_next = sine_amp;
      SHAPE_SQUARE: amp_next = square_amp;
      SHAPE_TRI:    amp_next = tri_amp;
      SHAPE_SAW:    amp_next = saw_amp;
      default:      amp_next = saw_amp;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      amp_valid <= 1'b0;
      amp_data  <= '0;
    end else if (adv) begin
      amp_valid <= 1'b1;
      amp_data  <= amp_next;
    end else if (amp_ready) begin
      amp_valid <= 1'b0;
    end
  end

  AST_RESET_EMPTY: assert property (@(posedge clk)
    rst |=> !amp_valid && idx == '0); // R1
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (amp_valid && !amp_ready) |=> amp_valid && $stable(amp_data)); // R3
  AST_DRAIN: assert property (@(posedge clk) disable iff (rst)
    (amp_valid && amp_ready && !step_en) |=> !amp_valid); // R4
  AST_SAW_TRACKS: assert property (@(posedge clk) disable iff (rst)
    (adv && wave_sel == 2'd3) |=> amp_data == $past(idx)); // R7
  AST_SQUARE_RAILS: assert property (@(posedge clk) disable iff (rst)
    (adv && wave_sel == 2'd1) |=> (amp_data == '0 || amp_data == AMP_TOP)); // R6
endmodule

// File: tb/tb_wg_funcgen.sv
`timescale 1ns/1ps
module tb_wg_funcgen;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       step_en = 1'b0;
  logic [1:0] wave_sel = 2'd0;
  logic       amp_ready = 1'b0;
  logic       amp_valid;
  logic [7:0] amp_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int m_idx = 0;
  bit m_valid = 1'b0;
  int m_amp = 0;

  always #2 clk = ~clk;

  wg_funcgen dut (
    .clk (clk), .rst (rst), .step_en (step_en), .wave_sel (wave_sel),
    .amp_ready (amp_ready), .amp_valid (amp_valid), .amp_data (amp_data)
  );

  function automatic int ref_amp(input int sel, input int i);
    real a;
    int  v;
    case (sel)
      0: begin
        a = 128.0 * $sin(6.283185307179586 * real'(i) / 256.0) + 128.0;
        v = $rtoi(a);
        if (v > 255) v = 255;
        if (v < 0) v = 0;
      end
      1: v = (i < 128) ? 255 : 0;
      2: begin
        if (i < 64)       v = 128 + 2 * i;
        else if (i < 192) v = 256 - 2 * (i - 63);
        else              v = 2 * (i - 191);
      end
      default: v = i;
    endcase
    return v;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one clock: update model from inputs, let edge pass, compare outputs
  task automatic cycle(input string tag);
    bit fire;
    fire = step_en && (!m_valid || amp_ready);
    if (fire) begin
      m_amp   = ref_amp(int'(wave_sel), m_idx);
      m_valid = 1'b1;
      m_idx   = (m_idx + 1) % 256;
    end else if (amp_ready) begin
      m_valid = 1'b0;
    end
    @(posedge clk);
    #1;
    check({tag, " valid"}, int'(amp_valid), int'(m_valid));
    if (m_valid) check({tag, " data"}, int'(amp_data), m_amp);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
    check("R1 reset valid", int'(amp_valid), 0);

    step_en = 1'b1;
    amp_ready = 1'b1;
    // R9 sine sweep; spot values at 0, 64, 192 handled by the formula
    wave_sel = 2'd0;
    for (int k = 0; k < 256; k++) cycle("R9 sine");
    wave_sel = 2'd1;
    for (int k = 0; k < 256; k++) cycle("R6 square");
    wave_sel = 2'd2;
    for (int k = 0; k < 256; k++) cycle("R8 triangle");
    wave_sel = 2'd3;
    for (int k = 0; k < 260; k++) cycle("R7 R2 saw wrap");

    // R5 select switching mid-stream keeps the phase
    for (int k = 0; k < 200; k++) begin
      wave_sel = 2'((k / 37) % 4);
      cycle("R5 switch");
    end

    // R3 stall with request held
    amp_ready = 1'b0;
    for (int k = 0; k < 6; k++) cycle("R3 stall");
    amp_ready = 1'b1;
    wave_sel = 2'd3;
    for (int k = 0; k < 4; k++) cycle("R2 resume");

    // R4 drain with no request, then idle
    step_en = 1'b0;
    cycle("R4 drain");
    check("R4 empty after drain", int'(amp_valid), 0);
    amp_ready = 1'b0;
    for (int k = 0; k < 5; k++) cycle("R2 idle");
    step_en = 1'b1;
    amp_ready = 1'b1;
    for (int k = 0; k < 8; k++) cycle("R2 restart");

    // R1 reset mid-stream, then phase restarts at 0
    rst = 1'b1;
    @(posedge clk);
    #1;
    rst = 1'b0;
    m_idx = 0;
    m_valid = 1'b0;
    check("R1 reset mid-stream valid", int'(amp_valid), 0);
    wave_sel = 2'd3;
    cycle("R1 saw after reset");
    check("R1 first index after reset", int'(amp_data), 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule